// File: doc/BRIEF.md
# Three-Mode Power Clock Controller

This block decides which clock domains of a small processor subsystem may toggle. It drives three enables: one for the execution and bus domain, one for the peripheral domain, and one for the crystal oscillator. The real gating cells and the oscillator are outside the block. Each enable is a registered level, and a stopped clock is modelled as its enable held at logic zero.

Software stores a target low-power mode in a 2-bit select field. The low-power state is entered only when a halt pulse arrives. Idle stops the execution/bus domain and leaves the peripherals running. Powerdown stops both domains and also turns the oscillator off.

A wake event brings the block back to active. From idle the return takes one cycle. From powerdown, the oscillator is restarted first, and the domain clocks are released only after a programmable settling count has run out. The two configuration fields can be written in every mode and keep their values in every mode.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, the state is active (`pm_state` = 2'b00). All three enables are 1, the mode-select field reads 2'b00, and the settle field reads its reset value, which is 16 by default.
- R2: In active, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1. `cpu_clk_en` is never 1 unless `per_clk_en` and `osc_en` are also 1.
- R3: In the active state, a halt pulse with select field 2'b01 and wake low moves the block to idle (`pm_state` = 2'b01) at that clock edge. Idle gives `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1.
- R4: In the active state, a halt pulse with select field 2'b10 and wake low moves the block to powerdown (`pm_state` = 2'b10) at that edge. Powerdown gives all three enables 0.
- R5: A halt pulse has no effect in these cases: the select field is 2'b00 or 2'b11; the state is idle, powerdown or settling; or wake is high in the same cycle.
- R6: A wake sampled in idle returns the block to active, with all enables 1, at that same edge.
- R7: A wake sampled in powerdown enters the settling state (`pm_state` = 2'b11) at that edge, with `osc_en`=1 and both domain enables 0. Active is reached exactly N+1 edges after the wake edge, where N is the settle field value sampled at the wake edge.
- R8: Wake has no effect in active or while settling.
- R9: A write to either configuration field is visible on its readback output one cycle later, in any mode. Between writes the fields hold their values through every mode. The halt decision uses the select value held before a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle request to enter the selected low-power mode |
| wake | input | 1 | Wake event (interrupt or similar) |
| cfg_mode_we | input | 1 | Write strobe for the mode-select field |
| cfg_mode_wdata | input | 2 | New mode-select value (01 idle, 10 powerdown, others none) |
| cfg_settle_we | input | 1 | Write strobe for the settle-count field |
| cfg_settle_wdata | input | CNT_W | New settle count |
| cfg_mode_q | output | 2 | Mode-select field readback |
| cfg_settle_q | output | CNT_W | Settle-count field readback |
| pm_state | output | 2 | Current state: 00 active, 01 idle, 10 powerdown, 11 settling |
| cpu_clk_en | output | 1 | Execution/bus domain clock enable |
| per_clk_en | output | 1 | Peripheral domain clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
Halt and wake decisions take effect on the same edge that samples them, because every enable is read straight from a flop that is loaded at that edge. The leave-powerdown path is the only one with a longer delay: it returns to active N+1 edges after the wake edge. The bench drives stimulus just after a falling edge, advances its behavioural model at the following rising edge, and compares every output at the next falling edge. A settling run is therefore checked on each intermediate cycle, not only at its end.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_IDLE   = 2'b01,
        PM_PDOWN  = 2'b10,
        PM_SETTLE = 2'b11
    } pm_state_e;

    localparam logic [1:0] SEL_IDLE  = 2'b01;
    localparam logic [1:0] SEL_PDOWN = 2'b10;

    typedef struct packed {
        pm_state_e state;
        logic      cpu_en;
        logic      per_en;
        logic      osc_en;
    } fsm_regs_t;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
    } clk_en_t;

    function automatic clk_en_t decode_en(pm_state_e s);
        clk_en_t e;
        case (s)
            PM_ACTIVE: e = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1};
            PM_IDLE:   e = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1};
            PM_PDOWN:  e = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b0};
            default:   e = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b1};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs #(
    parameter int unsigned          CNT_W      = 8,
    parameter logic [CNT_W-1:0]     SETTLE_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    input  logic             settle_we,
    input  logic [CNT_W-1:0] settle_wdata,
    output logic [1:0]       mode_sel,
    output logic [CNT_W-1:0] settle_val
);

    typedef struct packed {
        logic [1:0]       mode;
        logic [CNT_W-1:0] settle;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_we) begin
            cfg_d.mode = mode_wdata;
        end
        if (settle_we) begin
            cfg_d.settle = settle_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode   <= 2'b00;
            cfg_q.settle <= SETTLE_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_sel   = cfg_q.mode;
    assign settle_val = cfg_q.settle;

endmodule

// File: rtl/pwr_settle_ctr.sv
module pwr_settle_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt,
    input  logic      wake,
    input  logic [1:0] mode_sel,
    input  logic      settle_done,
    output pm_state_e state,
    output logic      cpu_en,
    output logic      per_en,
    output logic      osc_en,
    output logic      settle_load,
    output logic      settling
);

    fsm_regs_t r_d, r_q;
    clk_en_t   en_next;

    always_comb begin
        r_d         = r_q;
        settle_load = 1'b0;
        case (r_q.state)
            PM_ACTIVE: begin
                if (halt && !wake) begin
                    if (mode_sel == SEL_IDLE) begin
                        r_d.state = PM_IDLE;
                    end else if (mode_sel == SEL_PDOWN) begin
                        r_d.state = PM_PDOWN;
                    end
                end
            end
            PM_IDLE: begin
                if (wake) begin
                    r_d.state = PM_ACTIVE;
                end
            end
            PM_PDOWN: begin
                if (wake) begin
                    r_d.state   = PM_SETTLE;
                    settle_load = 1'b1;
                end
            end
            default: begin
                if (settle_done) begin
                    r_d.state = PM_ACTIVE;
                end
            end
        endcase
        en_next    = decode_en(r_d.state);
        r_d.cpu_en = en_next.cpu_en;
        r_d.per_en = en_next.per_en;
        r_d.osc_en = en_next.osc_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= PM_ACTIVE;
            r_q.cpu_en <= 1'b1;
            r_q.per_en <= 1'b1;
            r_q.osc_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.state;
    assign cpu_en   = r_q.cpu_en;
    assign per_en   = r_q.per_en;
    assign osc_en   = r_q.osc_en;
    assign settling = (r_q.state == PM_SETTLE);

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned      CNT_W      = 8,
    parameter logic [CNT_W-1:0] SETTLE_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             wake,
    input  logic             cfg_mode_we,
    input  logic [1:0]       cfg_mode_wdata,
    input  logic             cfg_settle_we,
    input  logic [CNT_W-1:0] cfg_settle_wdata,
    output logic [1:0]       cfg_mode_q,
    output logic [CNT_W-1:0] cfg_settle_q,
    output logic [1:0]       pm_state,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en
);

    logic      settle_load;
    logic      settling;
    logic      settle_done;
    pm_state_e state;

    pwr_cfg_regs #(
        .CNT_W      (CNT_W),
        .SETTLE_RST (SETTLE_RST)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_we      (cfg_mode_we),
        .mode_wdata   (cfg_mode_wdata),
        .settle_we    (cfg_settle_we),
        .settle_wdata (cfg_settle_wdata),
        .mode_sel     (cfg_mode_q),
        .settle_val   (cfg_settle_q)
    );

    pwr_settle_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (cfg_settle_q),
        .run      (settling),
        .done     (settle_done)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (halt_req),
        .wake        (wake),
        .mode_sel    (cfg_mode_q),
        .settle_done (settle_done),
        .state       (state),
        .cpu_en      (cpu_clk_en),
        .per_en      (per_clk_en),
        .osc_en      (osc_en),
        .settle_load (settle_load),
        .settling    (settling)
    );

    assign pm_state = state;

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req,
    input logic             wake,
    input logic             cfg_mode_we,
    input logic             cfg_settle_we,
    input logic [1:0]       cfg_mode_q,
    input logic [CNT_W-1:0] cfg_settle_q,
    input logic [1:0]       pm_state,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en
);

    p_cpu_needs_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (per_clk_en && osc_en));

    p_idle_gating_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b01) |-> (!cpu_clk_en && per_clk_en && osc_en));

    p_halt_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b00 && halt_req && !wake && cfg_mode_q == 2'b01) |=> (pm_state == 2'b01));

    p_pdown_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b10) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    p_pdown_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b10 && !wake) |=> (pm_state == 2'b10));

    p_idle_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b01 && wake) |=> (pm_state == 2'b00 && cpu_clk_en));

    p_pdown_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b10 && wake) |=> (pm_state == 2'b11 && osc_en && !cpu_clk_en && !per_clk_en));

    p_active_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'b00 && wake) |=> (pm_state == 2'b00));

    p_mode_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_we |=> $stable(cfg_mode_q));

    p_settle_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_settle_we |=> $stable(cfg_settle_q));

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_req      (halt_req),
    .wake          (wake),
    .cfg_mode_we   (cfg_mode_we),
    .cfg_settle_we (cfg_settle_we),
    .cfg_mode_q    (cfg_mode_q),
    .cfg_settle_q  (cfg_settle_q),
    .pm_state      (pm_state),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .osc_en        (osc_en)
);

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic       wake = 1'b0;
    logic       cfg_mode_we = 1'b0;
    logic [1:0] cfg_mode_wdata = 2'b00;
    logic       cfg_settle_we = 1'b0;
    logic [7:0] cfg_settle_wdata = 8'd0;
    logic [1:0] cfg_mode_q;
    logic [7:0] cfg_settle_q;
    logic [1:0] pm_state;
    logic       cpu_clk_en, per_clk_en, osc_en;

    int checks = 0;
    int fails  = 0;

    // behavioural reference: 0 active, 1 idle, 2 powerdown, 3 settling
    int m_state = 0;
    int m_cnt   = 0;
    int m_sel   = 0;
    int m_set   = 16;

    always #4 clk = ~clk;

    pwr_clk_ctrl uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .halt_req         (halt_req),
        .wake             (wake),
        .cfg_mode_we      (cfg_mode_we),
        .cfg_mode_wdata   (cfg_mode_wdata),
        .cfg_settle_we    (cfg_settle_we),
        .cfg_settle_wdata (cfg_settle_wdata),
        .cfg_mode_q       (cfg_mode_q),
        .cfg_settle_q     (cfg_settle_q),
        .pm_state         (pm_state),
        .cpu_clk_en       (cpu_clk_en),
        .per_clk_en       (per_clk_en),
        .osc_en           (osc_en)
    );

    task automatic compare(input string tag);
        logic ec, ep, eo;
        ec = (m_state == 0);
        ep = (m_state <= 1);
        eo = (m_state != 2);
        checks++;
        if (pm_state !== 2'(m_state) || cpu_clk_en !== ec || per_clk_en !== ep ||
            osc_en !== eo || cfg_mode_q !== 2'(m_sel) || cfg_settle_q !== 8'(m_set)) begin
            fails++;
            $display("FAIL %s: got st=%0d cpu=%b per=%b osc=%b sel=%0d set=%0d exp st=%0d cpu=%b per=%b osc=%b sel=%0d set=%0d",
                     tag, pm_state, cpu_clk_en, per_clk_en, osc_en, cfg_mode_q, cfg_settle_q,
                     m_state, ec, ep, eo, m_sel, m_set);
        end
    endtask

    task automatic step(input logic h, input logic w, input logic mwe, input logic [1:0] md,
                        input logic swe, input logic [7:0] sd, input string tag);
        halt_req = h; wake = w;
        cfg_mode_we = mwe; cfg_mode_wdata = md;
        cfg_settle_we = swe; cfg_settle_wdata = sd;
        @(posedge clk);
        case (m_state)
            0: if (h && !w && m_sel == 1) m_state = 1;
               else if (h && !w && m_sel == 2) m_state = 2;
            1: if (w) m_state = 0;
            2: if (w) begin m_state = 3; m_cnt = m_set; end
            default: if (m_cnt == 0) m_state = 0; else m_cnt--;
        endcase
        if (mwe) m_sel = md;
        if (swe) m_set = sd;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 0, 8'd0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        quiet(3, "R2 active all on");

        step(0, 0, 1, 2'd1, 0, 8'd0, "R9 write select idle");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R3 halt to idle");
        quiet(2, "R3 idle gating");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R5 halt in idle ignored");
        step(0, 0, 1, 2'd2, 0, 8'd0, "R9 write in idle");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R6 wake from idle");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R8 wake in active");

        step(0, 0, 1, 2'd0, 0, 8'd0, "R9 select none");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R5 halt sel 00");
        step(0, 0, 1, 2'd3, 0, 8'd0, "R9 select 11");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R5 halt sel 11");
        step(1, 0, 1, 2'd1, 0, 8'd0, "R9 halt uses old select");
        step(1, 1, 0, 2'd0, 0, 8'd0, "R5 halt with wake");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R3 halt to idle again");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R6 wake again");

        step(0, 0, 0, 2'd0, 1, 8'd3, "R9 write settle");
        step(0, 0, 1, 2'd2, 0, 8'd0, "R9 select powerdown");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R4 halt to powerdown");
        quiet(2, "R4 powerdown all off");
        step(1, 0, 1, 2'd1, 0, 8'd0, "R9 write in powerdown");
        step(0, 0, 1, 2'd2, 0, 8'd0, "R9 restore select");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R7 wake from powerdown");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R8 wake while settling");
        step(1, 0, 0, 2'd0, 1, 8'd9, "R5 halt while settling");
        quiet(3, "R7 settle countdown");

        step(0, 0, 0, 2'd0, 1, 8'd0, "R9 settle zero");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R4 powerdown again");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R7 wake zero settle");
        quiet(2, "R7 zero settle exit");

        step(0, 0, 0, 2'd0, 1, 8'd1, "R9 settle one");
        step(1, 0, 0, 2'd0, 0, 8'd0, "R4 powerdown third");
        step(0, 1, 0, 2'd0, 0, 8'd0, "R7 wake settle one");
        quiet(3, "R7 settle one exit");
        quiet(2, "R2 final active");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule